// File: doc/BRIEF.md
# Processor-Side Request Packetizer

This block sits between a processor's data-memory port and a 32-bit flit network channel. The processor can have only one access in flight. When a read or write request arrives, the block captures the address, byte select and write data. It sends the request out as a header flit followed by an address flit. A write also sends a data flit. The block then listens on the return channel for the matching response.

A read completes when a read-response header arrives, then an echoed address flit, then a data flit. The data is handed to the processor. A write completes when a write-response header arrives, then its address flit. That address flit acts as the acknowledge. The processor is stalled for the whole exchange. A one-cycle done pulse ends the exchange.

The destination memory id is derived from the address. The address space is split into 32 KiB banks. The id is the bank number plus 32, so a header flit can never be all zeros. The address flit carries only the offset inside the bank.

Top module: `cpu_flit_bridge`

## Requirements
- R1: While reset is asserted and after its release, `tx_valid`, `rx_ready`, `cpu_stall`, `cpu_done` and `type_err` are low until a request is accepted.
- R2: A read request accepted in idle (`cpu_req`=1, `cpu_we`=0) produces exactly two outbound flits, header then address. Each flit is transferred only on a clock edge where `tx_valid` and `tx_ready` are both high.
- R3: A write request (`cpu_we`=1) produces exactly three outbound flits, in the order header, address, data, where the data flit equals `cpu_wdata`.
- R4: The header flit layout is as follows.
  - Bits [31:30] hold the packet kind: 00 write request, 01 read request, 10 write response, 11 read response.
  - Bits [29:24] hold the processor id parameter.
  - Bits [23:16] hold the memory id.
  - Bits [15:12] hold the byte select.
  - Bits [11:4] hold the waiting count, sent as zero.
  - Bits [3:0] are zero.
- R5: The memory id equals 32 plus (address >> 15), truncated to 8 bits. The address flit equals address & 0x7FFF. For example, 0xABCD gives id 33 and offset 0x2BCD.
- R6: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_flit` is unchanged on the next cycle.
- R7: After a read's flits are sent, `rx_ready` is high. The block accepts a read-response header, then the echoed address, then data. On the cycle after the data flit is accepted, `cpu_done` is high for one cycle and `cpu_rdata` equals that data.
- R8: After a write's flits are sent, the block accepts a write-response header and then one address flit. On the next cycle `cpu_done` pulses, and `rx_ready` is low because no third flit is taken.
- R9: A response header whose kind field [31:30] does not match the pending request (10 for a write, 11 for a read) is consumed and discarded. `type_err` is high on the following cycle, and the block keeps waiting for a correct header.
- R10: `cpu_stall` is high from the cycle after acceptance until the cycle of `cpu_done`. While it is high, `cpu_req` is ignored and produces no outbound flits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Processor request strobe, sampled in idle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Byte select |
| cpu_wdata | input | 32 | Write data |
| cpu_stall | output | 1 | Transaction in flight |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Read data, valid with `cpu_done` for reads |
| tx_valid | output | 1 | Outbound flit valid |
| tx_ready | input | 1 | Outbound channel ready |
| tx_flit | output | 32 | Outbound flit |
| rx_valid | input | 1 | Inbound flit valid |
| rx_ready | output | 1 | Block accepts an inbound flit |
| rx_flit | input | 32 | Inbound flit |
| type_err | output | 1 | Mismatched response header seen (one cycle per header) |

## Verification
Once a request is accepted, the header appears on `tx_flit` one cycle later. Each following outbound flit appears one cycle after the previous handshake edge. `cpu_done` and `type_err` come from registers, so each is due exactly one cycle after the clock edge that consumed the deciding inbound flit.

The bench drives inputs shortly after the rising edge and samples outputs on the falling edge. It therefore observes every handshake and every pulse in the cycle it is due. The expected flits and completions come from a scoreboard queue that the driver fills from the address arithmetic. Every outbound flit or done pulse that arrives with nothing queued for it counts as a failure.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

  localparam int FLIT_W = 32;

  typedef enum logic [1:0] {
    PK_WR_REQ = 2'b00,
    PK_RD_REQ = 2'b01,
    PK_WR_RSP = 2'b10,
    PK_RD_RSP = 2'b11
  } pkt_kind_e;

  typedef enum logic [1:0] {
    TX_HDR  = 2'd0,
    TX_ADDR = 2'd1,
    TX_DATA = 2'd2
  } tx_sel_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TX_HDR  = 3'd1,
    ST_TX_ADDR = 3'd2,
    ST_TX_DATA = 3'd3,
    ST_RX_HDR  = 3'd4,
    ST_RX_ADDR = 3'd5,
    ST_RX_DATA = 3'd6
  } seq_state_e;

  typedef struct packed {
    pkt_kind_e   kind;
    logic [5:0]  cpu_id;
    logic [7:0]  mem_id;
    logic [3:0]  bsel;
    logic [7:0]  waited;
    logic [3:0]  spare;
  } hdr_t;

endpackage

// File: rtl/cfb_bank_map.sv
module cfb_bank_map #(
  parameter int ADDR_W      = 32,
  parameter int BANK_BITS   = 15,
  parameter int MEM_ID_BASE = 32
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        mem_id,
  output logic [ADDR_W-1:0] offset
);
  localparam logic [ADDR_W-1:0] OFF_MASK = {ADDR_W{1'b1}} >> (ADDR_W - BANK_BITS);

  // bank index plus base, kept to the 8-bit id field
  assign mem_id = 8'(addr >> BANK_BITS) + 8'(MEM_ID_BASE);
  assign offset = addr & OFF_MASK;
endmodule

// File: rtl/cfb_hdr_pack.sv
module cfb_hdr_pack
  import cfb_pkg::*;
#(
  parameter int CPU_ID = 5
) (
  input  pkt_kind_e          kind,
  input  logic [7:0]         mem_id,
  input  logic [3:0]         bsel,
  output logic [FLIT_W-1:0]  flit
);
  hdr_t h;

  always_comb begin
    h.kind   = kind;
    h.cpu_id = 6'(CPU_ID);
    h.mem_id = mem_id;
    h.bsel   = bsel;
    h.waited = '0;
    h.spare  = '0;
    flit     = h;
  end
endmodule

// File: rtl/cfb_seq.sv
module cfb_seq
  import cfb_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    cpu_req,
  input  logic    is_wr,
  input  logic    tx_ready,
  input  logic    rx_valid,
  input  logic    rx_kind_ok,
  output logic    cap_en,
  output logic    tx_valid,
  output tx_sel_e tx_sel,
  output logic    rx_ready,
  output logic    rdata_en,
  output logic    done_set,
  output logic    err_set,
  output logic    busy
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    cap_en   = 1'b0;
    tx_valid = 1'b0;
    tx_sel   = TX_HDR;
    rx_ready = 1'b0;
    rdata_en = 1'b0;
    done_set = 1'b0;
    err_set  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        cap_en = cpu_req;
        if (cpu_req) state_d = ST_TX_HDR;
      end
      ST_TX_HDR: begin
        tx_valid = 1'b1;
        if (tx_ready) state_d = ST_TX_ADDR;
      end
      ST_TX_ADDR: begin
        tx_valid = 1'b1;
        tx_sel   = TX_ADDR;
        if (tx_ready) state_d = is_wr ? ST_TX_DATA : ST_RX_HDR;
      end
      ST_TX_DATA: begin
        tx_valid = 1'b1;
        tx_sel   = TX_DATA;
        if (tx_ready) state_d = ST_RX_HDR;
      end
      ST_RX_HDR: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          if (rx_kind_ok) state_d = ST_RX_ADDR;
          else            err_set = 1'b1;
        end
      end
      ST_RX_ADDR: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          if (is_wr) begin
            done_set = 1'b1;
            state_d  = ST_IDLE;
          end else begin
            state_d  = ST_RX_DATA;
          end
        end
      end
      ST_RX_DATA: begin
        rx_ready = 1'b1;
        if (rx_valid) begin
          rdata_en = 1'b1;
          done_set = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/cpu_flit_bridge.sv
module cpu_flit_bridge
  import cfb_pkg::*;
#(
  parameter int CPU_ID      = 5,
  parameter int BANK_BITS   = 15,
  parameter int MEM_ID_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [FLIT_W-1:0] cpu_addr,
  input  logic [3:0]        cpu_be,
  input  logic [FLIT_W-1:0] cpu_wdata,
  output logic              cpu_stall,
  output logic              cpu_done,
  output logic [FLIT_W-1:0] cpu_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [FLIT_W-1:0] tx_flit,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [FLIT_W-1:0] rx_flit,
  output logic              type_err
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta, rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_int_n <= rst_meta;
    end
  end

  logic [7:0]        map_id;
  logic [FLIT_W-1:0] map_off;

  cfb_bank_map #(
    .ADDR_W(FLIT_W), .BANK_BITS(BANK_BITS), .MEM_ID_BASE(MEM_ID_BASE)
  ) u_map (
    .addr(cpu_addr), .mem_id(map_id), .offset(map_off)
  );

  // captured request
  logic              is_wr_q;
  logic [7:0]        mem_id_q;
  logic [3:0]        be_q;
  logic [FLIT_W-1:0] off_q, wdata_q, rdata_q;
  logic              done_q, err_q;

  logic    cap_en, rdata_en, done_set, err_set, busy, rx_kind_ok;
  tx_sel_e tx_sel;

  cfb_seq u_seq (
    .clk(clk), .rst_n(rst_int_n), .cpu_req(cpu_req), .is_wr(is_wr_q),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_kind_ok(rx_kind_ok),
    .cap_en(cap_en), .tx_valid(tx_valid), .tx_sel(tx_sel),
    .rx_ready(rx_ready), .rdata_en(rdata_en), .done_set(done_set),
    .err_set(err_set), .busy(busy)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      is_wr_q  <= 1'b0;
      mem_id_q <= '0;
      be_q     <= '0;
      off_q    <= '0;
      wdata_q  <= '0;
    end else if (cap_en) begin
      is_wr_q  <= cpu_we;
      mem_id_q <= map_id;
      be_q     <= cpu_be;
      off_q    <= map_off;
      wdata_q  <= cpu_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    rdata_q <= '0;
    else if (rdata_en) rdata_q <= rx_flit;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_set;
      err_q  <= err_set;
    end
  end

  pkt_kind_e         req_kind, rsp_kind;
  logic [FLIT_W-1:0] hdr_flit;

  assign req_kind   = is_wr_q ? PK_WR_REQ : PK_RD_REQ;
  assign rsp_kind   = is_wr_q ? PK_WR_RSP : PK_RD_RSP;
  assign rx_kind_ok = (rx_flit[31:30] == rsp_kind);

  cfb_hdr_pack #(.CPU_ID(CPU_ID)) u_hdr (
    .kind(req_kind), .mem_id(mem_id_q), .bsel(be_q), .flit(hdr_flit)
  );

  always_comb begin
    case (tx_sel)
      TX_ADDR: tx_flit = off_q;
      TX_DATA: tx_flit = wdata_q;
      default: tx_flit = hdr_flit;
    endcase
  end

  assign cpu_stall = busy;
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;
  assign type_err  = err_q;
endmodule

// File: rtl/cfb_checker.sv
module cfb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        tx_valid,
  input logic        tx_ready,
  input logic [31:0] tx_flit,
  input logic        rx_ready,
  input logic        cpu_stall,
  input logic        cpu_done,
  input logic        type_err
);
  // first flit of every request is a request-kind header with zero waiting count and spare bits
  assert_hdr_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_valid) |-> (tx_flit[31] == 1'b0) && (tx_flit[11:0] == 12'h000));

  assert_hold_under_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_flit)));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_done_no_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> !rx_ready);

  assert_err_keeps_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
    type_err |-> (cpu_stall && rx_ready));

  assert_channel_only_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid || rx_ready) |-> cpu_stall);
endmodule

bind cpu_flit_bridge cfb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_flit(tx_flit), .rx_ready(rx_ready), .cpu_stall(cpu_stall),
  .cpu_done(cpu_done), .type_err(type_err)
);

// File: tb/cpu_flit_bridge_test.sv
module cpu_flit_bridge_test;
  localparam int CPU_ID = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cpu_req, cpu_we;
  logic [31:0] cpu_addr, cpu_wdata;
  logic [3:0]  cpu_be;
  logic        cpu_stall, cpu_done;
  logic [31:0] cpu_rdata;
  logic        tx_valid, tx_ready;
  logic [31:0] tx_flit;
  logic        rx_valid, rx_ready;
  logic [31:0] rx_flit;
  logic        type_err;

  always #10 clk = ~clk;

  cpu_flit_bridge #(.CPU_ID(CPU_ID)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_addr(cpu_addr), .cpu_be(cpu_be), .cpu_wdata(cpu_wdata),
    .cpu_stall(cpu_stall), .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_flit(tx_flit),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_flit(rx_flit),
    .type_err(type_err)
  );

  int checks = 0, fails = 0;
  int err_seen = 0, err_exp = 0, unexpected = 0;
  int cyc = 0;
  bit bp_mode = 1'b0;

  logic [31:0] txq[$];
  string       txtag[$];
  logic [31:0] rdq[$];
  bit          isrdq[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [31:0] hdr(input logic [1:0] k, input logic [7:0] mid, input logic [3:0] be);
    return {k, 6'(CPU_ID), mid, be, 8'h00, 4'h0};
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // outbound backpressure pattern
  initial begin
    tx_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      tx_ready = bp_mode ? ((cyc % 3) != 1) : 1'b1;
    end
  end

  // monitor: compares outputs against the scoreboard away from the rising edge
  logic        held_v = 1'b0;
  logic [31:0] held_f = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held_v) check(tx_valid && (tx_flit == held_f), "R6 held flit", tx_flit, held_f);
      held_v = tx_valid && !tx_ready;
      held_f = tx_flit;
      if (tx_valid && tx_ready) begin
        if (txq.size() == 0) begin
          unexpected++;
          check(1'b0, "R10 unexpected outbound flit", tx_flit, 32'h0);
        end else begin
          logic [31:0] e;
          string t;
          e = txq.pop_front();
          t = txtag.pop_front();
          check(tx_flit == e, t, tx_flit, e);
        end
      end
      if (cpu_done) begin
        if (rdq.size() == 0) begin
          check(1'b0, "R10 unexpected done", 32'h1, 32'h0);
        end else begin
          logic [31:0] e;
          bit r;
          e = rdq.pop_front();
          r = isrdq.pop_front();
          check(!cpu_stall, "R10 stall low at done", {31'h0, cpu_stall}, 32'h0);
          if (r) check(cpu_rdata == e, "R7 read data", cpu_rdata, e);
          else   check(!rx_ready, "R8 no third response flit", {31'h0, rx_ready}, 32'h0);
        end
      end
      if (type_err) err_seen++;
    end
  end

  task automatic send_flit(input logic [31:0] f);
    rx_valid = 1'b1;
    rx_flit  = f;
    forever begin
      @(negedge clk);
      if (rx_ready) break;
    end
    @(posedge clk); #2;
    rx_valid = 1'b0;
  endtask

  task automatic do_txn(input bit wr, input logic [31:0] addr, input logic [3:0] be,
                        input logic [31:0] wd, input logic [31:0] rd_resp, input int bad_hdrs);
    logic [7:0]  mid;
    logic [31:0] off;
    mid = 8'(addr >> 15) + 8'd32;
    off = addr & 32'h0000_7FFF;
    txq.push_back(hdr(wr ? 2'b00 : 2'b01, mid, be)); txtag.push_back("R4 R5 header flit");
    txq.push_back(off);                              txtag.push_back("R5 address flit");
    if (wr) begin
      txq.push_back(wd); txtag.push_back("R3 data flit");
    end
    rdq.push_back(rd_resp);
    isrdq.push_back(!wr);
    @(posedge clk); #2;
    cpu_req = 1'b1; cpu_we = wr; cpu_addr = addr; cpu_be = be; cpu_wdata = wd;
    @(posedge clk); #2;
    cpu_req = 1'b0;
    while (txq.size() != 0) @(posedge clk);
    #2;
    check(cpu_stall && rx_ready, "R7 waiting for response", {30'h0, cpu_stall, rx_ready}, 32'h3);
    for (int i = 0; i < bad_hdrs; i++) begin
      err_exp++;
      if (i % 2 == 0) send_flit(hdr(wr ? 2'b11 : 2'b10, mid, be));
      else            send_flit(hdr(wr ? 2'b00 : 2'b01, mid, be));
    end
    if (bad_hdrs > 0) begin
      // request while busy must be ignored
      cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = 32'h0000_1234;
      repeat (2) @(posedge clk);
      #2;
      cpu_req = 1'b0;
      repeat (2) @(posedge clk);
      #2;
      check(cpu_stall && rx_ready, "R9 still waiting after bad header", {30'h0, cpu_stall, rx_ready}, 32'h3);
      check(err_seen == err_exp, "R9 error pulses", 32'(err_seen), 32'(err_exp));
    end
    send_flit(hdr(wr ? 2'b10 : 2'b11, mid, be));
    send_flit(off);
    if (!wr) send_flit(rd_resp);
    while (rdq.size() != 0) @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_be = '0; cpu_wdata = '0;
    rx_valid = 1'b0; rx_flit = '0;
    repeat (3) @(negedge clk);
    check(!tx_valid && !rx_ready && !cpu_stall && !cpu_done && !type_err, "R1 reset outputs",
          {27'h0, tx_valid, rx_ready, cpu_stall, cpu_done, type_err}, 32'h0);
    @(posedge clk); #2;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!tx_valid && !rx_ready && !cpu_stall && !cpu_done && !type_err, "R1 after release",
          {27'h0, tx_valid, rx_ready, cpu_stall, cpu_done, type_err}, 32'h0);

    // R2 read, no backpressure, bank 1
    do_txn(1'b0, 32'h0000_ABCD, 4'hF, 32'h0, 32'hDEAD_BEEF, 0);
    // R3 write, backpressure, bank 2
    bp_mode = 1'b1;
    do_txn(1'b1, 32'h0001_0004, 4'h3, 32'h1234_5678, 32'h0, 0);
    // R9 R10 read with two bad headers and an ignored request, bank 15
    do_txn(1'b0, 32'h0007_8010, 4'h1, 32'h0, 32'hA5A5_0F0F, 2);
    // R9 write with one bad header, bank 0
    bp_mode = 1'b0;
    do_txn(1'b1, 32'h0000_7FFC, 4'hC, 32'hCAFE_F00D, 32'h0, 1);
    // back-to-back read with backpressure
    bp_mode = 1'b1;
    do_txn(1'b0, 32'h0003_0000, 4'h8, 32'h0, 32'h0000_0001, 0);

    repeat (3) @(negedge clk);
    check(txq.size() == 0, "R2 all flits sent", 32'(txq.size()), 32'h0);
    check(err_seen == err_exp, "R9 total error pulses", 32'(err_seen), 32'(err_exp));
    check(unexpected == 0, "R10 no flits from ignored request", 32'(unexpected), 32'h0);
    check(!cpu_stall && !tx_valid && !rx_ready, "R1 idle at end",
          {29'h0, cpu_stall, tx_valid, rx_ready}, 32'h0);
    finish_run();
  end
endmodule